// File: doc/BRIEF.md
# Sample Stream Corner Turner

This block reorders the output of a wide sampler so that a correlator can be built as a single row of multipliers instead of a full square. It receives N lanes of 2-bit samples in parallel. The lanes are time-interleaved, so on input word t, lane k holds sample t·N + k of one stream. It emits N lanes in which each lane holds a run of consecutive samples. Within one segment of S = N·L samples, output lane j carries samples j·L through j·L + L − 1. The correlation products across the seam between two neighbouring lanes' runs are lost. That small loss is accepted in exchange for the simpler array.

Storage is an on-chip ring of two segment-sized banks. While one bank fills in interleaved order, the other is read across all lanes in segment order. A read offset, given in samples and taken only at segment boundaries, moves the whole output back in time. The same offset serves as bulk delay and as the displacement that lets chained correlator arrays see later lags. Output runs one word per accepted input word and starts once the first segment has been stored.

Top module: `corner_turn`

## Requirements
- R1: On each accepted input word t, lane k occupies in_data bits [2k+1:2k] and holds stream sample t·N + k. Words are counted from reset.
- R2: On the output word that follows input word t (t ≥ L), lane j carries stream sample s·S + j·L + i − D. Here s = t/L − 1, i = t mod L, S = N·L, and D is the offset in force for that segment.
- R3: out_valid stays low until L input words have been accepted after reset.
- R4: Once the first segment has been stored, out_valid is high in exactly the cycle after each cycle with in_valid high. Gaps in the input give gaps in the output.
- R5: out_start is high exactly on the output word with i = 0. It is never high without out_valid.
- R6: The offset is captured from cfg_offset only on an input word with i = 0. Changes of cfg_offset at any other position have no effect on the output.
- R7: A requested sample whose index is negative (first output segment, j·L + i < D) is output as code 00.
- R8: cfg_offset is log2(L) bits wide, so every value from 0 to L−1 is legal. Even at L−1, no output sample is corrupted by writes of the segment being filled.
- R9: While reset is asserted, out_valid and out_start are low and out_data is all zeros.
- R10: Each sample is a 2-bit code carried unchanged from input to output. Output lane j occupies out_data bits [2j+1:2j].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 2·N | N interleaved 2-bit samples |
| cfg_offset | input | log2(L) | Read offset in samples, taken at segment start |
| out_valid | output | 1 | Output word qualifier |
| out_start | output | 1 | Marks the first word of an output segment |
| out_data | output | 2·N | N lanes of segment-ordered samples |

## Verification
Two things happen together in every steady cycle: one word of the next segment is written into the ring, and samples of the previous segment are read from it. With the offset at its largest value, the read addresses come within one word of the write window. The bench holds the offset at L−1 while the input has gaps and compares every lane against a sample history it keeps itself, so any overlap would show up as a wrong code. A second collision happens at the segment boundary. There the offset capture and the first read of the new segment occur in the same cycle, and the bench changes cfg_offset exactly on that word and also in the middle of segments.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int unsigned SMP_W = 2;
  typedef logic [SMP_W-1:0] smp_t;
endpackage

// File: rtl/ct_wr_ctrl.sv
module ct_wr_ctrl #(
  parameter int L = 32,
  localparam int LW = $clog2(L),
  localparam int WW = LW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic [WW-1:0] word_ptr,
  output logic          primed,
  output logic          first_rd
);
  logic [WW-1:0] ptr_q, ptr_d;
  logic          primed_q, primed_d;
  logic          first_q, first_d;
  logic          seg_end;

  assign seg_end = (ptr_q[LW-1:0] == LW'(L - 1));

  always_comb begin
    ptr_d    = ptr_q;
    primed_d = primed_q;
    first_d  = first_q;
    if (in_valid) begin
      ptr_d = ptr_q + WW'(1);
      if (seg_end) begin
        if (!primed_q) begin
          primed_d = 1'b1;
          first_d  = 1'b1;
        end else begin
          first_d  = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      primed_q <= 1'b0;
      first_q  <= 1'b0;
    end else if (in_valid) begin
      ptr_q    <= ptr_d;
      primed_q <= primed_d;
      first_q  <= first_d;
    end
  end

  assign word_ptr = ptr_q;
  assign primed   = primed_q;
  assign first_rd = first_q;

  // R3: once a segment is stored, output stays enabled until reset
  p_primed_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    primed_q |=> primed_q);
endmodule

// File: rtl/ct_ring_mem.sv
module ct_ring_mem
  import ct_pkg::*;
#(
  parameter int N = 32,
  parameter int L = 32,
  localparam int LW = $clog2(L),
  localparam int NW = $clog2(N),
  localparam int WW = LW + 1,
  localparam int AW = NW + LW + 1,
  localparam int DEPTH = 2 * N * L
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [WW-1:0]        wr_word,
  input  logic [N*SMP_W-1:0]   wr_data,
  input  logic [N*AW-1:0]      rd_addr,
  output logic [N*SMP_W-1:0]   rd_data
);
  smp_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int k = 0; k < N; k++) begin
        mem[{wr_word, NW'(k)}] <= wr_data[k*SMP_W +: SMP_W];
      end
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_rd
    assign rd_data[j*SMP_W +: SMP_W] = mem[rd_addr[j*AW +: AW]];
  end
endmodule

// File: rtl/ct_rd_gen.sv
module ct_rd_gen
  import ct_pkg::*;
#(
  parameter int N = 32,
  parameter int L = 32,
  localparam int LW = $clog2(L),
  localparam int NW = $clog2(N),
  localparam int WW = LW + 1,
  localparam int AW = NW + LW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 primed,
  input  logic                 first_rd,
  input  logic [WW-1:0]        word_ptr,
  input  logic [LW-1:0]        cfg_offset,
  output logic [N*AW-1:0]      rd_addr,
  input  logic [N*SMP_W-1:0]   rd_data,
  output logic                 out_valid,
  output logic                 out_start,
  output logic [N*SMP_W-1:0]   out_data
);
  logic [LW-1:0]      phase;
  logic               segbit;
  logic [LW-1:0]      off_q, off_d, off_use;
  logic               fire;
  logic [N-1:0]       hide;
  logic [N*SMP_W-1:0] shown;
  logic               vld_q, vld_d, st_q, st_d;
  logic [N*SMP_W-1:0] dat_q, dat_d;

  assign phase  = word_ptr[LW-1:0];
  assign segbit = word_ptr[LW];
  assign fire   = in_valid & primed;

  always_comb begin
    off_use = (phase == '0) ? cfg_offset : off_q;
    off_d   = off_q;
    if (in_valid && phase == '0) off_d = cfg_offset;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) off_q <= '0;
    else if (in_valid) off_q <= off_d;
  end

  for (genvar j = 0; j < N; j++) begin : g_lane
    logic [NW+LW-1:0] pos;
    assign pos = {NW'(j), phase};
    assign rd_addr[j*AW +: AW] = {~segbit, pos} - {{(NW + 1){1'b0}}, off_use};
    assign hide[j] = first_rd && (pos < {{NW{1'b0}}, off_use});
    assign shown[j*SMP_W +: SMP_W] = hide[j] ? '0 : rd_data[j*SMP_W +: SMP_W];
  end

  always_comb begin
    vld_d = fire;
    st_d  = fire && (phase == '0);
    dat_d = fire ? shown : dat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      st_q  <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      st_q  <= st_d;
      dat_q <= dat_d;
    end
  end

  assign out_valid = vld_q;
  assign out_start = st_q;
  assign out_data  = dat_q;

  // R8: lane 0 (closest to the writer) never reads the word being written
  logic [AW-1:0] gap0;
  assign gap0 = rd_addr[AW-1:0] - {word_ptr, {NW{1'b0}}};
  p_rd_clear_of_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hide[0]) |-> (gap0 >= AW'(N)));
endmodule

// File: rtl/corner_turn.sv
module corner_turn
  import ct_pkg::*;
#(
  parameter int N = 32,
  parameter int L = 32,
  localparam int LW = $clog2(L),
  localparam int NW = $clog2(N),
  localparam int WW = LW + 1,
  localparam int AW = NW + LW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [N*SMP_W-1:0] in_data,
  input  logic [LW-1:0]      cfg_offset,
  output logic               out_valid,
  output logic               out_start,
  output logic [N*SMP_W-1:0] out_data
);
  logic               rst_s1, rst_s2;
  logic [WW-1:0]      word_ptr;
  logic               primed, first_rd;
  logic [N*AW-1:0]    rd_addr;
  logic [N*SMP_W-1:0] rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  ct_wr_ctrl #(.L(L)) u_wr (
    .clk(clk), .rst_n(rst_s2), .in_valid(in_valid),
    .word_ptr(word_ptr), .primed(primed), .first_rd(first_rd)
  );

  ct_ring_mem #(.N(N), .L(L)) u_mem (
    .clk(clk), .we(in_valid & rst_s2), .wr_word(word_ptr), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  ct_rd_gen #(.N(N), .L(L)) u_rd (
    .clk(clk), .rst_n(rst_s2), .in_valid(in_valid), .primed(primed),
    .first_rd(first_rd), .word_ptr(word_ptr), .cfg_offset(cfg_offset),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_start(out_start), .out_data(out_data)
  );

  // R4: every output word answers an input word one cycle earlier
  p_out_follows_in_r4: assert property (@(posedge clk) disable iff (!rst_s2)
    out_valid |-> $past(in_valid));
  // R5: the segment marker only rides on a valid word
  p_start_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_s2)
    out_start |-> out_valid);
  // R3: nothing leaves before the first segment is stored
  p_no_out_before_fill_r3: assert property (@(posedge clk) disable iff (!rst_s2)
    !primed |=> !out_valid);
endmodule

// File: tb/corner_turn_tb.sv
module corner_turn_tb;
  localparam int N = 4;
  localparam int L = 8;
  localparam int S = N * L;
  localparam int LW = $clog2(L);
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 20000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             in_valid;
  logic [N*2-1:0]   in_data;
  logic [LW-1:0]    cfg_offset;
  logic             out_valid, out_start;
  logic [N*2-1:0]   out_data;

  corner_turn #(.N(N), .L(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_offset(cfg_offset), .out_valid(out_valid), .out_start(out_start),
    .out_data(out_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 0;
  int    smp [0:4095];
  int    word_cnt, off_lat;
  bit    have_exp, exp_valid, exp_start;
  int    exp_lane [N];
  string exp_tag [N];
  string vtag, cur_tag;

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    if (have_exp) begin
      check({vtag, " out_valid"}, int'(out_valid), int'(exp_valid));
      check("R5 out_start", int'(out_start), int'(exp_start));
      if (exp_valid) begin
        for (int j = 0; j < N; j++)
          check($sformatf("%s/R10 lane %0d", exp_tag[j], j),
                int'(out_data[j*2 +: 2]), exp_lane[j]);
      end
    end
  endtask

  // drive one cycle, predict the output of the following cycle
  task automatic step(bit v, int off);
    @(negedge clk);
    compare();
    in_valid   = v;
    cfg_offset = LW'(off);
    for (int k = 0; k < N; k++)
      in_data[k*2 +: 2] = 2'(smp[word_cnt * N + k]);
    vtag = (word_cnt <= L) ? "R3" : "R4";
    exp_valid = 0;
    exp_start = 0;
    if (v) begin
      int ph;
      ph = word_cnt % L;
      if (ph == 0) off_lat = off;
      if (word_cnt >= L) begin
        int sg;
        sg = word_cnt / L - 1;
        exp_valid = 1;
        exp_start = (ph == 0);
        for (int j = 0; j < N; j++) begin
          int idx;
          idx = sg * S + j * L + ph - off_lat;
          exp_lane[j] = (idx < 0) ? 0 : smp[idx];
          exp_tag[j]  = (idx < 0) ? "R7" : cur_tag;
        end
      end
      word_cnt++;
    end
    have_exp = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    have_exp = 0;
    word_cnt = 0;
    off_lat = 0;
    repeat (3) @(negedge clk);
    check("R9 out_valid in reset", int'(out_valid), 0);
    check("R9 out_start in reset", int'(out_start), 0);
    check("R9 out_data in reset", int'(out_data), 0);
    rst_n = 1'b1;
    repeat (3) step(0, 0);
  endtask

  initial begin
    int lfsr;
    lfsr = 16'hACE1;
    for (int i = 0; i < 4096; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
      smp[i] = lfsr & 3;
    end
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = '0;
    cfg_offset = '0;
    cur_tag = "R2";

    // run A: offset from the start, zero fill of the first segment
    do_reset();
    cur_tag = "R2";
    for (int w = 0; w < 4 * L; w++) step(1, 5);
    step(0, 5);

    // run B
    do_reset();
    cur_tag = "R1";
    for (int w = 0; w < 3 * L; w++) step(1, 0);
    cur_tag = "R4";
    for (int c = 0; c < 6 * L; c++) step((c % 3) != 2, 1);
    cur_tag = "R2";
    for (int w = 0; w < 3 * L; w++) step(1, (word_cnt / L) % L);
    cur_tag = "R6";
    for (int w = 0; w < 3 * L; w++)
      step(1, ((word_cnt % L) == 0) ? 3 : (word_cnt % L) + 2);
    cur_tag = "R8";
    for (int c = 0; c < 6 * L; c++) step((c % 4) != 1, L - 1);
    for (int w = 0; w < 2 * L; w++) step(1, L - 1);
    step(0, 0);
    step(0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule